// File: doc/BRIEF.md
# Operand Belt with Reorder and Scratch Spill

This block holds the most recent results of a datapath as a fixed-length belt addressed by position, where position 0 is the newest value. Each cycle up to `NUM_IN` results may be dropped at the front. Existing entries move toward higher positions, and whatever is pushed past the last position is lost. Read ports return the value and an error flag for any position, so a consumer names its operands by how recently they were produced.

Two commands renumber the belt from a list of positions. The ordering command (conform) places the named values at the front in list order. The keeping command (rescue) keeps the named values in the order they already had. Both commands invalidate every entry that the list does not name. A small scratchpad lets a value outlive belt churn: a spill copies a belt position into a slot, and a fill later pushes that slot back in at position 0.

Top module: `belt_queue`

## Requirements
- R1: After reset every belt position is invalid. A read port addressing an invalid position raises its `rd_err` bit in the same cycle. Every scratchpad slot resets to zero.
- R2: Read port `k` takes its position from `rd_pos[k*PW +: PW]`. It returns the stored value on `rd_data[k*DATA_W +: DATA_W]` combinationally. When the position is valid, `rd_err[k]` is 0.
- R3: `res_cnt` (clamped to `NUM_IN`) selects how many result lanes enter at the next edge. Lane `j` of `res_data[j*DATA_W +: DATA_W]` lands at position `j`, and the lane lands valid. Older entries move up by the number of inserted values.
- R4: Entries pushed beyond position `BELT_LEN-1` are discarded.
- R5: `cmd_op`=1 (conform) with `cmd_cnt`=n places the entry at position `cmd_list[k*PW +: PW]` at new position `k`, for k<n. The entry keeps its data and valid bit.
- R6: After an accepted conform, positions n and above are invalid.
- R7: A conform whose first n list entries repeat a position is rejected. So is a conform or rescue with `cmd_cnt` greater than `LIST_LEN`. A rejected command raises `cmd_err` in the same cycle and the belt is not reordered.
- R8: `cmd_op`=2 (rescue) keeps exactly the positions named in the first n list entries. The kept entries are packed to the front in ascending original position order, and all others become invalid. A repeated position in the list is harmless.
- R9: When a reorder and insertions fall in the same cycle, the reorder is applied first and the inserted values then enter at the front.
- R10: With `spill_en`, the value at `spill_pos` is copied into slot `spill_slot` at the edge. If that position is invalid, `spill_err` is raised in the same cycle and the slot keeps its old content.
- R11: With `fill_en`, slot `fill_slot` (its content before any same-cycle spill) enters at position 0. The result lanes then follow at positions 1 and up.
- R12: In a cycle with no accepted reorder, no results and no fill, the belt is unchanged. `cmd_op`=0 and 3 mean no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_cnt | input | CW | Number of result lanes to insert |
| res_data | input | NUM_IN*DATA_W | Result lanes, lane 0 lowest |
| cmd_op | input | 2 | 0 none, 1 conform, 2 rescue, 3 none |
| cmd_cnt | input | LCW | Number of list entries used |
| cmd_list | input | LIST_LEN*PW | Position list, entry 0 lowest |
| spill_en | input | 1 | Copy a belt position into a slot |
| spill_pos | input | PW | Belt position to spill |
| spill_slot | input | SW | Destination slot |
| fill_en | input | 1 | Push a slot value to position 0 |
| fill_slot | input | SW | Source slot |
| rd_pos | input | NUM_RD*PW | Read positions |
| rd_data | output | NUM_RD*DATA_W | Read values |
| rd_err | output | NUM_RD | Read of an invalid position |
| cmd_err | output | 1 | Reorder command rejected |
| spill_err | output | 1 | Spill of an invalid position |

## Verification
The two error flags are combinational, so the bench drives a command half a cycle before the edge and compares `cmd_err` and `spill_err` shortly after driving, before that edge. Belt contents change at the next rising edge, one register deep. The bench therefore restores idle inputs at the following falling edge and then sweeps every position through both combinational read ports. Scratchpad effects take two steps to observe: the slot is written at one edge, and its content only becomes visible through a later fill and a read sweep after that fill's edge.

// File: rtl/belt_pkg.sv
package belt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CONFORM = 2'd1,
    OP_RESCUE  = 2'd2,
    OP_SPARE   = 2'd3
  } belt_op_e;
endpackage

// File: rtl/belt_reorder.sv
module belt_reorder
  import belt_pkg::*;
#(
  parameter int BELT_LEN = 8,
  parameter int DATA_W   = 32,
  parameter int LIST_LEN = 4,
  parameter int PW       = 3,
  parameter int LCW      = 3
) (
  input  logic [BELT_LEN-1:0][DATA_W-1:0] cur_data,
  input  logic [BELT_LEN-1:0]             cur_val,
  input  belt_op_e                        op,
  input  logic [LCW-1:0]                  cnt,
  input  logic [LIST_LEN-1:0][PW-1:0]     list,
  output logic [BELT_LEN-1:0][DATA_W-1:0] re_data,
  output logic [BELT_LEN-1:0]             re_val,
  output logic                            list_bad,
  output logic                            applied
);
  function automatic logic list_repeats(input logic [LIST_LEN-1:0][PW-1:0] l,
                                        input logic [LCW-1:0] n);
    logic r;
    r = 1'b0;
    for (int i = 1; i < LIST_LEN; i++)
      for (int j = 0; j < i; j++)
        if (i < int'(n) && l[i] == l[j]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [BELT_LEN-1:0] named_set(input logic [LIST_LEN-1:0][PW-1:0] l,
                                                    input logic [LCW-1:0] n);
    logic [BELT_LEN-1:0] m;
    m = '0;
    for (int k = 0; k < LIST_LEN; k++)
      if (k < int'(n)) m[l[k]] = 1'b1;
    return m;
  endfunction

  logic is_cf, is_rs, too_long;
  logic [BELT_LEN-1:0] keep;
  logic [PW:0] wr_at;

  assign is_cf    = (op == OP_CONFORM);
  assign is_rs    = (op == OP_RESCUE);
  assign too_long = int'(cnt) > LIST_LEN;
  assign list_bad = ((is_cf || is_rs) && too_long) || (is_cf && list_repeats(list, cnt));
  assign applied  = (is_cf || is_rs) && !list_bad;
  assign keep     = named_set(list, cnt);

  always_comb begin
    re_data = cur_data;
    re_val  = cur_val;
    wr_at   = '0;
    if (applied) begin
      re_data = '0;
      re_val  = '0;
      if (is_cf) begin
        for (int k = 0; k < LIST_LEN; k++)
          if (k < int'(cnt)) begin
            re_data[k] = cur_data[list[k]];
            re_val[k]  = cur_val[list[k]];
          end
      end else begin
        for (int p = 0; p < BELT_LEN; p++)
          if (keep[p]) begin
            re_data[wr_at[PW-1:0]] = cur_data[p];
            re_val[wr_at[PW-1:0]]  = cur_val[p];
            wr_at = wr_at + 1'b1;
          end
      end
    end
  end
endmodule

// File: rtl/belt_insert.sv
module belt_insert #(
  parameter int BELT_LEN = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_IN   = 2,
  parameter int PW       = 3,
  parameter int CW       = 2,
  parameter int IW       = 2
) (
  input  logic [BELT_LEN-1:0][DATA_W-1:0] mid_data,
  input  logic [BELT_LEN-1:0]             mid_val,
  input  logic [CW-1:0]                   res_cnt,
  input  logic [NUM_IN-1:0][DATA_W-1:0]   res_data,
  input  logic                            fill_en,
  input  logic [DATA_W-1:0]               fill_data,
  output logic [BELT_LEN-1:0][DATA_W-1:0] nxt_data,
  output logic [BELT_LEN-1:0]             nxt_val,
  output logic [IW-1:0]                   ins_n
);
  function automatic int lanes_used(input logic [CW-1:0] c);
    return (int'(c) > NUM_IN) ? NUM_IN : int'(c);
  endfunction

  logic [BELT_LEN-1:0][DATA_W-1:0] items;
  logic [PW-1:0] src;

  assign ins_n = IW'(lanes_used(res_cnt) + (fill_en ? 1 : 0));

  always_comb begin
    items = '0;
    if (fill_en) begin
      items[0] = fill_data;
      for (int j = 0; j < NUM_IN; j++) items[j+1] = res_data[j];
    end else begin
      for (int j = 0; j < NUM_IN; j++) items[j] = res_data[j];
    end
  end

  always_comb begin
    src = '0;
    for (int p = 0; p < BELT_LEN; p++) begin
      if (p < int'(ins_n)) begin
        nxt_data[p] = items[p];
        nxt_val[p]  = 1'b1;
      end else begin
        src = PW'(p - int'(ins_n));
        nxt_data[p] = mid_data[src];
        nxt_val[p]  = mid_val[src];
      end
    end
  end
endmodule

// File: rtl/belt_scratch.sv
module belt_scratch #(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32,
  parameter int SW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SW-1:0]     rd_slot,
  output logic [DATA_W-1:0] rd_data
);
  logic [SLOTS-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) mem <= '0;
    else if (wr_en) mem[wr_slot] <= wr_data;
  end

  assign rd_data = mem[rd_slot];

  // R10: a granted spill lands in its slot
  a_r10_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_slot)] == $past(wr_data)));
endmodule

// File: rtl/belt_queue.sv
module belt_queue
  import belt_pkg::*;
#(
  parameter int BELT_LEN = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_IN   = 2,
  parameter int NUM_RD   = 2,
  parameter int LIST_LEN = 4,
  parameter int SLOTS    = 8,
  localparam int PW  = $clog2(BELT_LEN),
  localparam int CW  = $clog2(NUM_IN + 1),
  localparam int LCW = $clog2(LIST_LEN + 1),
  localparam int SW  = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            res_cnt,
  input  logic [NUM_IN*DATA_W-1:0] res_data,
  input  logic [1:0]               cmd_op,
  input  logic [LCW-1:0]           cmd_cnt,
  input  logic [LIST_LEN*PW-1:0]   cmd_list,
  input  logic                     spill_en,
  input  logic [PW-1:0]            spill_pos,
  input  logic [SW-1:0]            spill_slot,
  input  logic                     fill_en,
  input  logic [SW-1:0]            fill_slot,
  input  logic [NUM_RD*PW-1:0]     rd_pos,
  output logic [NUM_RD*DATA_W-1:0] rd_data,
  output logic [NUM_RD-1:0]        rd_err,
  output logic                     cmd_err,
  output logic                     spill_err
);
  localparam int IW = $clog2(NUM_IN + 2);

  logic [BELT_LEN-1:0][DATA_W-1:0] data_q, re_data, nxt_data;
  logic [BELT_LEN-1:0]             val_q, re_val, nxt_val;
  logic                            reorder_go, spill_wr;
  logic [IW-1:0]                   ins_n;
  logic [DATA_W-1:0]               fill_data;
  belt_op_e                        op;

  assign op = belt_op_e'(cmd_op);

  belt_reorder #(.BELT_LEN(BELT_LEN), .DATA_W(DATA_W), .LIST_LEN(LIST_LEN),
                 .PW(PW), .LCW(LCW)) u_reorder (
    .cur_data(data_q), .cur_val(val_q), .op(op), .cnt(cmd_cnt),
    .list(cmd_list), .re_data(re_data), .re_val(re_val),
    .list_bad(cmd_err), .applied(reorder_go));

  belt_insert #(.BELT_LEN(BELT_LEN), .DATA_W(DATA_W), .NUM_IN(NUM_IN),
                .PW(PW), .CW(CW), .IW(IW)) u_insert (
    .mid_data(re_data), .mid_val(re_val), .res_cnt(res_cnt),
    .res_data(res_data), .fill_en(fill_en), .fill_data(fill_data),
    .nxt_data(nxt_data), .nxt_val(nxt_val), .ins_n(ins_n));

  assign spill_err = spill_en && !val_q[spill_pos];
  assign spill_wr  = spill_en && val_q[spill_pos];

  belt_scratch #(.SLOTS(SLOTS), .DATA_W(DATA_W), .SW(SW)) u_scratch (
    .clk(clk), .rst_n(rst_n), .wr_en(spill_wr), .wr_slot(spill_slot),
    .wr_data(data_q[spill_pos]), .rd_slot(fill_slot), .rd_data(fill_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      val_q  <= '0;
    end else begin
      data_q <= nxt_data;
      val_q  <= nxt_val;
    end
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    logic [PW-1:0] pos;
    assign pos = rd_pos[k*PW +: PW];
    assign rd_data[k*DATA_W +: DATA_W] = data_q[pos];
    assign rd_err[k] = !val_q[pos];
  end

  // R12: nothing requested, nothing moves
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reorder_go && !cmd_err && ins_n == '0) |=> ($stable(val_q) && $stable(data_q)));
  // R7: a rejected list leaves the belt alone when nothing is inserted
  a_r7_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && ins_n == '0) |=> ($stable(val_q) && $stable(data_q)));
  // R6: an accepted conform leaves at most cmd_cnt valid entries
  a_r6_conform_count: assert property (@(posedge clk) disable iff (!rst_n)
    (reorder_go && op == OP_CONFORM && ins_n == '0)
      |=> ($countones(val_q) <= int'($past(cmd_cnt))));
  // R8: an accepted rescue leaves at most cmd_cnt valid entries
  a_r8_rescue_count: assert property (@(posedge clk) disable iff (!rst_n)
    (reorder_go && op == OP_RESCUE && ins_n == '0)
      |=> ($countones(val_q) <= int'($past(cmd_cnt))));
  // R3: any insertion makes the front valid
  a_r3_front_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_n != '0) |=> val_q[0]);
  // R10: a spill of an invalid position never reaches the scratchpad
  a_r10_no_bad_spill: assert property (@(posedge clk) disable iff (!rst_n)
    spill_err |-> !u_scratch.wr_en);
endmodule

// File: tb/belt_queue_test.sv
`timescale 1ns/1ps
module belt_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  res_cnt = '0;
  logic [63:0] res_data = '0;
  logic [1:0]  cmd_op = '0;
  logic [2:0]  cmd_cnt = '0;
  logic [11:0] cmd_list = '0;
  logic        spill_en = 1'b0;
  logic [2:0]  spill_pos = '0;
  logic [2:0]  spill_slot = '0;
  logic        fill_en = 1'b0;
  logic [2:0]  fill_slot = '0;
  logic [5:0]  rd_pos = '0;
  logic [63:0] rd_data;
  logic [1:0]  rd_err;
  logic        cmd_err, spill_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_d [8];
  bit          m_v [8];
  logic [31:0] m_s [8];

  always #2 clk = ~clk;

  belt_queue uut (.*);

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_belt(input string req);
    for (int p = 0; p < 8; p++) begin
      rd_pos = {3'(7 - p), 3'(p)};
      #0.2;
      expect_eq(req, {31'd0, rd_err[0]}, {31'd0, !m_v[p]});
      if (m_v[p]) expect_eq(req, rd_data[31:0], m_d[p]);
      expect_eq(req, {31'd0, rd_err[1]}, {31'd0, !m_v[7-p]});
      if (m_v[7-p]) expect_eq(req, rd_data[63:32], m_d[7-p]);
    end
  endtask

  task automatic step(input string req, input int op, input int cnt, input int l0,
                      input int l1, input int l2, input int l3, input int rc,
                      input logic [31:0] r0, input logic [31:0] r1,
                      input bit fe, input int fs, input bit se, input int sp, input int ss);
    int lst [4];
    logic [31:0] td [8];
    bit tv [8];
    logic [31:0] items [8];
    logic [31:0] fv;
    bit bad, named;
    int n, ni;
    lst = '{l0, l1, l2, l3};
    @(negedge clk);
    cmd_op = 2'(op); cmd_cnt = 3'(cnt);
    cmd_list = {3'(l3), 3'(l2), 3'(l1), 3'(l0)};
    res_cnt = 2'(rc); res_data = {r1, r0};
    fill_en = fe; fill_slot = 3'(fs);
    spill_en = se; spill_pos = 3'(sp); spill_slot = 3'(ss);
    bad = 0;
    if ((op == 1 || op == 2) && cnt > 4) bad = 1;
    if (op == 1)
      for (int i = 1; i < 4; i++)
        for (int j = 0; j < i; j++)
          if (i < cnt && lst[i] == lst[j]) bad = 1;
    #0.5;
    expect_eq({req, " cmd_err"}, {31'd0, cmd_err}, {31'd0, bad});
    expect_eq({req, " spill_err"}, {31'd0, spill_err}, {31'd0, se && !m_v[sp]});
    fv = m_s[fs];
    if (se && m_v[sp]) m_s[ss] = m_d[sp];
    for (int p = 0; p < 8; p++) begin td[p] = m_d[p]; tv[p] = m_v[p]; end
    if (!bad && op == 1) begin
      for (int p = 0; p < 8; p++) begin td[p] = 0; tv[p] = 0; end
      for (int k = 0; k < cnt; k++) begin td[k] = m_d[lst[k]]; tv[k] = m_v[lst[k]]; end
    end else if (!bad && op == 2) begin
      for (int p = 0; p < 8; p++) begin td[p] = 0; tv[p] = 0; end
      n = 0;
      for (int p = 0; p < 8; p++) begin
        named = 0;
        for (int k = 0; k < cnt; k++) if (lst[k] == p) named = 1;
        if (named) begin td[n] = m_d[p]; tv[n] = m_v[p]; n++; end
      end
    end
    ni = 0;
    if (fe) begin items[ni] = fv; ni++; end
    if (rc > 0) begin items[ni] = r0; ni++; end
    if (rc > 1) begin items[ni] = r1; ni++; end
    for (int p = 0; p < 8; p++) begin
      if (p < ni) begin m_d[p] = items[p]; m_v[p] = 1; end
      else begin m_d[p] = td[p-ni]; m_v[p] = tv[p-ni]; end
    end
    @(negedge clk);
    cmd_op = 0; cmd_cnt = 0; res_cnt = 0; fill_en = 0; spill_en = 0;
  endtask

  task automatic push2(input logic [31:0] a, input logic [31:0] b);
    step("R3", 0, 0, 0, 0, 0, 0, 2, a, b, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk_belt("R1 reset");
  endtask

  task automatic t_insert;
    push2(32'h11, 32'h12); push2(32'h21, 32'h22);
    chk_belt("R3 insert");
    push2(32'h31, 32'h32); push2(32'h41, 32'h42);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 32'h51, 0, 0, 0, 0, 0, 0);
    chk_belt("R4 overflow");
    chk_belt("R2 read");
  endtask

  task automatic t_conform;
    step("R5", 1, 3, 5, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_belt("R5 R6 conform");
  endtask

  task automatic t_reject;
    push2(32'h61, 32'h62); push2(32'h71, 32'h72); push2(32'h81, 32'h82);
    step("R7 dup", 1, 3, 1, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_belt("R7 dup hold");
    step("R7 long", 2, 5, 0, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_belt("R7 long hold");
  endtask

  task automatic t_rescue;
    step("R8", 2, 4, 6, 2, 4, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_belt("R8 rescue");
  endtask

  task automatic t_mixed;
    step("R9", 1, 2, 2, 0, 0, 0, 1, 32'h91, 0, 0, 0, 0, 0, 0);
    chk_belt("R9 reorder then insert");
  endtask

  task automatic t_scratch;
    step("R10 spill", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 5);
    step("R10 bad spill", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 5);
    step("R11 fill", 0, 0, 0, 0, 0, 0, 1, 32'hA1, 0, 1, 5, 0, 0, 0);
    chk_belt("R10 R11 fill");
    step("R11 unwritten slot", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0);
    chk_belt("R1 R11 zero slot");
  endtask

  task automatic t_idle;
    step("R12", 3, 2, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_belt("R12 idle");
  endtask

  initial begin
    for (int p = 0; p < 8; p++) begin m_d[p] = 0; m_v[p] = 0; m_s[p] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_insert();
    t_conform();
    t_reject();
    t_rescue();
    t_mixed();
    t_scratch();
    t_idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule